// File: doc/BRIEF.md
# Output Discharge and Mode Sequencer

This block orders the events around a USB charging port's power path. It drives the gate enable of the port power switch, the enable of the data-line pass switches and the enable of the output discharge path. It also reports which charging mode is currently applied. A new charging mode never reaches the port directly. The sequencer first turns both switches off and discharges the output for a fixed hold interval, and only then commits the requested mode and turns the switches back on.

The same discharge-first rule applies when the port comes up. The port comes up when enable rises, when the supply leaves undervoltage lockout, or when a fault clears. It also applies in automatic dedicated-charging mode when the charge-detection logic asks to swap between the two divider schemes. An overcurrent input is deglitched in both directions. The deglitched overcurrent and an overtemperature flag together drive an active-low fault output, and any fault opens every switch. The hold time and the deglitch time are counts of clock cycles set by parameters.

Top module: `mode_seq`

## Requirements
- R1: While reset is held and just after it is released, `pwr_on` and `dsw_on` are 0, `dchg_on` is 1, `mode_out` is 0 and `fault_n` is 1.
- R2: One clock after `en` is sampled low, `pwr_on` and `dsw_on` are 0 and `dchg_on` is 1, and this holds for as long as `en` stays low.
- R3: One clock after `uvlo_ok` is sampled low, `pwr_on` and `dsw_on` are 0 and `dchg_on` is 1, for as long as `uvlo_ok` stays low.
- R4: When the port becomes allowed to run, `dchg_on` is 1 for exactly HOLD_CYC cycles with both switches off. Then `pwr_on` and `dsw_on` rise together and `mode_out[MODE_W-1:0]` equals `mode_req`. The port becomes allowed to run when `en` and `uvlo_ok` are high and there is no fault.
- R5: A change of `mode_req` while the port is on opens both switches and sets `dchg_on` on the next clock. The new mode is applied after exactly HOLD_CYC discharge cycles. `mode_out` changes only in the cycle in which `pwr_on` rises.
- R6: A change of `mode_req` during a discharge restarts the hold count from zero. The mode applied at the end is the latest one requested.
- R7: In the automatic mode (mode code AUTO_MODE, default 3'd4), `mode_out[MODE_W]` gives the divider scheme: 0 is the first scheme and 1 is the second. Entering the automatic mode from another mode selects the first scheme. A `div_swap` pulse while the port is on starts a HOLD_CYC discharge, after which the scheme bit is inverted, in either direction. `div_swap` has no effect in any other mode.
- R8: `pwr_on` and `dchg_on` are never 1 in the same cycle.
- R9: `oc_raw` must differ from its filtered value for DGL_CYC consecutive clock samples before the filtered value follows it, in both directions. Shorter pulses have no effect on `fault_n`.
- R10: `fault_n` is the inverse of (`ot_flt` OR filtered overcurrent), with no added delay. One clock after a fault is seen while `en` and `uvlo_ok` are high, `pwr_on`, `dsw_on` and `dchg_on` are all 0. When the fault clears, the R4 discharge sequence runs again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Port enable; low turns the port off and discharges it |
| uvlo_ok | input | 1 | High when the supply is above its lockout threshold |
| mode_req | input | MODE_W | Requested charging mode code |
| div_swap | input | 1 | Single-cycle request to swap divider scheme in automatic mode |
| ot_flt | input | 1 | Overtemperature flag |
| oc_raw | input | 1 | Undeglitched overcurrent flag |
| pwr_on | output | 1 | Power-switch gate enable |
| dsw_on | output | 1 | Data-line switch enable |
| dchg_on | output | 1 | Output discharge enable |
| mode_out | output | MODE_W+1 | Applied mode; top bit is the divider scheme |
| fault_n | output | 1 | Active-low fault |

## Verification
Every switch and mode output is a decode of registered state, so it answers one clock after the input sample that caused the change. A newly requested mode therefore appears HOLD_CYC+1 clocks after the request: one clock to enter discharge, then HOLD_CYC discharge cycles. The filtered overcurrent moves DGL_CYC clocks after `oc_raw` changes, and the switches open one clock after that. `fault_n` follows `ot_flt` in the same cycle. The bench updates a behavioural model on each rising edge, compares all outputs 5 ns later, and counts discharge cycles at falling edges so that each phase length is checked exactly.

// File: rtl/mode_seq.sv
module mode_seq #(
  parameter int HOLD_CYC = 16,
  parameter int DGL_CYC  = 4,
  parameter int MODE_W   = 3,
  parameter int AUTO_MODE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              uvlo_ok,
  input  logic [MODE_W-1:0] mode_req,
  input  logic              div_swap,
  input  logic              ot_flt,
  input  logic              oc_raw,
  output logic              pwr_on,
  output logic              dsw_on,
  output logic              dchg_on,
  output logic [MODE_W:0]   mode_out,
  output logic              fault_n
);
  localparam int TW = $clog2(HOLD_CYC + 1);
  localparam int DW = $clog2(DGL_CYC + 1);
  localparam logic [MODE_W-1:0] AUTO = MODE_W'(AUTO_MODE);

  typedef enum logic [1:0] {S_OFF, S_DCHG, S_ACT, S_FLT} st_t;

  st_t              st;
  logic [TW-1:0]    tmr;
  logic [DW-1:0]    dcnt;
  logic             oc_q;
  logic [MODE_W-1:0] pend, cur;
  logic             pend_div, cur_div;
  logic             flt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      oc_q <= 1'b0;
      dcnt <= '0;
    end else if (oc_raw == oc_q) begin
      dcnt <= '0;
    end else if (dcnt == DW'(DGL_CYC - 1)) begin
      oc_q <= oc_raw;
      dcnt <= '0;
    end else begin
      dcnt <= dcnt + 1'b1;
    end

  assign flt     = ot_flt | oc_q;
  assign fault_n = ~flt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= S_OFF;
      tmr      <= '0;
      pend     <= '0;
      pend_div <= 1'b0;
      cur      <= '0;
      cur_div  <= 1'b0;
    end else if (!en || !uvlo_ok) begin
      st <= S_OFF;
    end else if (flt) begin
      st <= S_FLT;
    end else begin
      case (st)
        S_OFF, S_FLT: begin
          st       <= S_DCHG;
          tmr      <= '0;
          pend     <= mode_req;
          pend_div <= 1'b0;
        end
        S_DCHG: begin
          if (mode_req != pend) begin
            pend     <= mode_req;
            pend_div <= 1'b0;
            tmr      <= '0;
          end else if (tmr == TW'(HOLD_CYC - 1)) begin
            st      <= S_ACT;
            cur     <= pend;
            cur_div <= pend_div;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: begin
          if (mode_req != cur) begin
            st       <= S_DCHG;
            pend     <= mode_req;
            pend_div <= 1'b0;
            tmr      <= '0;
          end else if (div_swap && cur == AUTO) begin
            st       <= S_DCHG;
            pend     <= cur;
            pend_div <= ~cur_div;
            tmr      <= '0;
          end
        end
      endcase
    end

  assign pwr_on   = (st == S_ACT);
  assign dsw_on   = (st == S_ACT);
  assign dchg_on  = (st == S_OFF) || (st == S_DCHG);
  assign mode_out = {cur_div, cur};
endmodule

// File: rtl/mode_seq_chk.sv
module mode_seq_chk #(
  parameter int HOLD_CYC = 16,
  parameter int MODE_W   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            uvlo_ok,
  input logic            pwr_on,
  input logic            dsw_on,
  input logic            dchg_on,
  input logic [MODE_W:0] mode_out,
  input logic            fault_n
);
  localparam int RW = $clog2(HOLD_CYC + 2);
  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) run <= '0;
    else if (!dchg_on) run <= '0;
    else if (run != RW'(HOLD_CYC + 1)) run <= run + 1'b1;

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_on && dchg_on));
  a_r2_en_low_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwr_on && !dsw_on && dchg_on));
  a_r3_uvlo_off: assert property (@(posedge clk) disable iff (!rst_n)
    !uvlo_ok |=> (!pwr_on && !dsw_on && dchg_on));
  a_r4_hold_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_on) |-> (run >= RW'(HOLD_CYC)));
  a_r5_commit_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_out) |-> $rose(pwr_on));
  a_r10_fault_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (en && uvlo_ok && !fault_n) |=> (!pwr_on && !dsw_on && !dchg_on));
endmodule

bind mode_seq mode_seq_chk #(.HOLD_CYC(HOLD_CYC), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .uvlo_ok(uvlo_ok), .pwr_on(pwr_on),
  .dsw_on(dsw_on), .dchg_on(dchg_on), .mode_out(mode_out), .fault_n(fault_n)
);

// File: tb/sim_mode_seq.sv
module sim_mode_seq;
  localparam int HOLD = 16;
  localparam int DGL  = 4;
  localparam int MW   = 3;
  localparam int AUTO = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 1'b0, uvlo_ok = 1'b1, div_swap = 1'b0, ot_flt = 1'b0, oc_raw = 1'b0;
  logic [MW-1:0] mode_req = 3'd1;
  logic pwr_on, dsw_on, dchg_on, fault_n;
  logic [MW:0] mode_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  mode_seq #(.HOLD_CYC(HOLD), .DGL_CYC(DGL), .MODE_W(MW), .AUTO_MODE(AUTO)) u0 (
    .clk(clk), .rst_n(rst_n), .en(en), .uvlo_ok(uvlo_ok), .mode_req(mode_req),
    .div_swap(div_swap), .ot_flt(ot_flt), .oc_raw(oc_raw), .pwr_on(pwr_on),
    .dsw_on(dsw_on), .dchg_on(dchg_on), .mode_out(mode_out), .fault_n(fault_n));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 off, 1 discharging, 2 on, 3 faulted
  int ph = 0, hold_left = 0, want = 0, want_div = 0, have = 0, have_div = 0;
  int oc_seen = 0, oc_run = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; hold_left = 0; want = 0; want_div = 0; have = 0; have_div = 0;
      oc_seen = 0; oc_run = 0;
    end else begin
      int f;
      f = ot_flt || oc_seen != 0;
      if (!en || !uvlo_ok) ph = 0;
      else if (f) ph = 3;
      else if (ph == 0 || ph == 3) begin
        ph = 1; hold_left = HOLD; want = mode_req; want_div = 0;
      end else if (ph == 1) begin
        if (mode_req != want) begin want = mode_req; want_div = 0; hold_left = HOLD; end
        else begin
          hold_left--;
          if (hold_left == 0) begin ph = 2; have = want; have_div = want_div; end
        end
      end else begin
        if (mode_req != have) begin ph = 1; want = mode_req; want_div = 0; hold_left = HOLD; end
        else if (div_swap && have == AUTO) begin
          ph = 1; want = have; want_div = 1 - have_div; hold_left = HOLD;
        end
      end
      if (int'(oc_raw) == oc_seen) oc_run = 0;
      else begin
        oc_run++;
        if (oc_run == DGL) begin oc_seen = oc_raw; oc_run = 0; end
      end
    end
    #5;
    if (rst_n) begin
      chk(pwr_on == (ph == 2), "R4 pwr_on", pwr_on, ph == 2);
      chk(dsw_on == (ph == 2), "R4 dsw_on", dsw_on, ph == 2);
      chk(dchg_on == (ph <= 1), "R2 dchg_on", dchg_on, ph <= 1);
      chk(int'(mode_out) == have_div * 8 + have, "R5 mode_out", mode_out, have_div * 8 + have);
      chk(fault_n == !(ot_flt || oc_seen != 0), "R9 fault_n", fault_n, !(ot_flt || oc_seen != 0));
      chk(!(pwr_on && dchg_on), "R8 overlap", pwr_on && dchg_on, 0);
    end
  end

  task automatic measure(output int n);
    int guard = 0;
    n = 0;
    do begin
      @(negedge clk);
      div_swap = 1'b0;
      if (dchg_on) n++;
      guard++;
    end while (!pwr_on && guard < 1000);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    chk(!pwr_on && !dsw_on && dchg_on && mode_out == 0 && fault_n, "R1 reset", pwr_on, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pwr_on && dchg_on && mode_out == 0 && fault_n, "R1 after release", dchg_on, 1);

    en = 1'b1; measure(n);
    chk(n == HOLD, "R4 power-up hold", n, HOLD);
    chk(mode_out == 4'd1, "R4 mode applied", mode_out, 1);

    mode_req = 3'd2; measure(n);
    chk(n == HOLD, "R5 change hold", n, HOLD);
    chk(mode_out == 4'd2, "R5 new mode", mode_out, 2);

    mode_req = 3'd3; n = 0;
    repeat (5) begin @(negedge clk); if (dchg_on) n++; end
    chk(n == 5 && mode_out == 4'd2, "R6 mid discharge", n, 5);
    mode_req = 3'(AUTO); measure(n);
    chk(n == HOLD, "R6 restarted hold", n, HOLD);
    chk(mode_out == 4'd4, "R6 latest mode, R7 first scheme", mode_out, 4);

    div_swap = 1'b1; measure(n);
    chk(n == HOLD, "R7 swap hold", n, HOLD);
    chk(mode_out == 4'd12, "R7 second scheme", mode_out, 12);
    div_swap = 1'b1; measure(n);
    chk(n == HOLD && mode_out == 4'd4, "R7 revert scheme", mode_out, 4);

    mode_req = 3'd1; measure(n);
    div_swap = 1'b1; @(negedge clk); div_swap = 1'b0;
    repeat (3) @(negedge clk);
    chk(pwr_on && !dchg_on && mode_out == 4'd1, "R7 swap ignored", mode_out, 1);

    en = 1'b0;
    repeat (10) begin
      @(negedge clk);
      chk(!pwr_on && !dsw_on && dchg_on, "R2 enable low", pwr_on, 0);
    end
    en = 1'b1; measure(n);
    chk(n == HOLD, "R2 re-enable hold", n, HOLD);

    uvlo_ok = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk(!pwr_on && !dsw_on && dchg_on, "R3 lockout", pwr_on, 0);
    end
    uvlo_ok = 1'b1; measure(n);
    chk(n == HOLD, "R3 recovery hold", n, HOLD);

    oc_raw = 1'b1;
    repeat (DGL - 1) @(negedge clk);
    oc_raw = 1'b0;
    repeat (DGL + 2) begin
      @(negedge clk);
      chk(fault_n && pwr_on, "R9 short pulse ignored", fault_n, 1);
    end

    oc_raw = 1'b1;
    repeat (DGL - 1) @(negedge clk);
    chk(fault_n, "R9 before deglitch", fault_n, 1);
    @(negedge clk);
    chk(!fault_n, "R9 after deglitch", fault_n, 0);
    @(negedge clk);
    chk(!pwr_on && !dsw_on && !dchg_on, "R10 overcurrent opens", pwr_on, 0);
    oc_raw = 1'b0;
    repeat (DGL - 1) @(negedge clk);
    chk(!fault_n, "R9 release deglitch", fault_n, 0);
    measure(n);
    chk(n == HOLD, "R10 recovery hold", n, HOLD);

    ot_flt = 1'b1; #1;
    chk(!fault_n, "R10 overtemp immediate", fault_n, 0);
    @(negedge clk);
    chk(!pwr_on && !dsw_on && !dchg_on, "R10 overtemp opens", pwr_on, 0);
    ot_flt = 1'b0; measure(n);
    chk(n == HOLD && mode_out == 4'd1, "R10 overtemp recovery", n, HOLD);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule